// File: doc/BRIEF.md
# Rewindable FIFO with Fill-Level Flags

A first-in first-out buffer on a single clock. It holds `DEPTH` words of `W` bits (1024 words of 9 bits unless set otherwise). Write, read, rewind and output-enable inputs are all active low and are sampled on the rising clock edge. The buffer reports its fill level on four active-low status outputs: full, empty, more-than-half-full, and a combined edge flag. The edge flag is low while the buffer is near empty or near full.

A rewind moves the read side back to memory location 0 and leaves the write side where it is. The words written since reset can then be read out a second time. The output enable controls only whether a read word is presented. A read with the output disabled still consumes its word. The idle state of the output is modelled as `rd_valid` low with `rd_data` at zero, in place of a high-impedance pin.

Writing in the same cycle as a rewind is a protocol violation. Its behaviour is left undefined, and an assertion flags it.

Top module: `fifo_rt`

## Requirements
- R1: While `rst` is high at a clock edge, the occupancy goes to 0 and both pointers go to location 0. After that edge, `full_n`=1, `half_n`=1, `empty_n`=0, `edge_n`=0 and `rd_valid`=0.
- R2: `full_n` is 0 exactly when DEPTH words are held. A write (`wr_n`=0) while full is ignored: the occupancy, the stored words and the write position stay unchanged.
- R3: `empty_n` is 0 exactly when no word is held. A read (`rd_n`=0) while empty is ignored, and `rd_valid` stays 0 in the next cycle.
- R4: A rewind (`rewind_n`=0, with `wr_n`=1) sets the read position to location 0 and leaves the write position unchanged. The occupancy becomes the write position, or DEPTH when the write position is 0 and at least DEPTH words have been written since reset.
- R5: `edge_n` is 0 when the occupancy is at most DEPTH/8, or at least DEPTH − DEPTH/8. It is 1 otherwise.
- R6: `half_n` is 0 exactly when the occupancy is greater than DEPTH/2.
- R7: A permitted read with `oe_n`=1 removes the oldest word. In the next cycle `rd_valid` is 0 and `rd_data` is 0.
- R8: A permitted read with `oe_n`=0 gives `rd_valid`=1 and the oldest word on `rd_data` in the next cycle. In every cycle that does not follow such a read, `rd_valid`=0 and `rd_data`=0.
- R9: A write and a read in the same cycle, both permitted, store one word and deliver one word. The occupancy does not change.
- R10: A read in the same cycle as a rewind is ignored. It produces no output word, and the rewind alone takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low |
| wr_data | input | W | Word to store |
| rd_n | input | 1 | Read strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| rewind_n | input | 1 | Rewind read side to location 0, active low |
| rd_data | output | W | Word read; 0 when not valid |
| rd_valid | output | 1 | rd_data carries a word this cycle |
| full_n | output | 1 | Low when full |
| empty_n | output | 1 | Low when empty |
| half_n | output | 1 | Low when more than half full |
| edge_n | output | 1 | Low in the bottom or top eighth of fill |

## Verification
The buffer is filled one word at a time from empty to full. This walks the occupancy across every flag threshold, so an off-by-one in any band edge shows up on its own flag. Reads with the output disabled are interleaved with reads with it enabled, which separates consuming a word from presenting it. A rewind after a partial drain, followed by a full drain, shows whether the replay starts at location 0 and stops at the write position. A long stretch of mixed traffic, including simultaneous reads and writes and strobes at the full and empty boundaries, then exercises the count arithmetic against the reference model in every cycle.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

    typedef struct packed {
        logic full_n;
        logic empty_n;
        logic half_n;
        logic edge_n;
    } fill_flags_t;

    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
        logic rewind;
    } ops_t;

    function automatic int band_size(int depth);
        return depth / 8;
    endfunction

    function automatic fill_flags_t decode_fill(int level, int depth);
        fill_flags_t f;
        int lo_lim;
        int hi_lim;
        lo_lim    = band_size(depth);
        hi_lim    = depth - band_size(depth);
        f.full_n  = (level != depth);
        f.empty_n = (level != 0);
        f.half_n  = !(level > depth / 2);
        f.edge_n  = !((level <= lo_lim) || (level >= hi_lim));
        return f;
    endfunction

endpackage

// File: rtl/fifo_rt_ptrs.sv
module fifo_rt_ptrs
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          rewind_n,
    output ops_t          ops,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] level
);

    logic at_full;
    logic at_empty;
    logic wrapped;

    assign at_full    = (level == CW'(DEPTH));
    assign at_empty   = (level == '0);
    assign ops.rewind = ~rewind_n;
    assign ops.wr_ok  = ~wr_n & ~at_full;
    assign ops.rd_ok  = ~rd_n & ~at_empty & rewind_n;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            level   <= '0;
            wrapped <= 1'b0;
        end else begin
            if (ops.wr_ok) begin
                wptr <= bump(wptr);
                if (wptr == AW'(DEPTH - 1))
                    wrapped <= 1'b1;
            end
            if (ops.rewind) begin
                rptr  <= '0;
                level <= (wptr == '0 && wrapped) ? CW'(DEPTH) : CW'(wptr);
            end else begin
                if (ops.rd_ok)
                    rptr <= bump(rptr);
                unique case ({ops.wr_ok, ops.rd_ok})
                    2'b10:   level <= level + 1'b1;
                    2'b01:   level <= level - 1'b1;
                    default: level <= level;
                endcase
            end
        end
    end

    // R2: occupancy never leaves its range
    a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH));

    // R2: a write strobe while full moves nothing
    a_r2_full_blocks_write: assert property (@(posedge clk) disable iff (rst)
        (at_full && !wr_n && rewind_n) |=> (wptr == $past(wptr)));

    // R3: a read strobe while empty moves nothing
    a_r3_empty_blocks_read: assert property (@(posedge clk) disable iff (rst)
        (at_empty && !rd_n && wr_n && rewind_n) |=> (level == '0 && rptr == $past(rptr)));

    // R4: rewind homes the read side and keeps the write side
    a_r4_rewind_home: assert property (@(posedge clk) disable iff (rst)
        (!rewind_n && wr_n) |=> (rptr == '0 && $stable(wptr)));

    // R4: writing together with a rewind is a protocol violation
    a_r4_no_write_on_rewind: assert property (@(posedge clk) disable iff (rst)
        !rewind_n |-> wr_n);

    // R9: a balanced read and write keep the occupancy
    a_r9_balanced: assert property (@(posedge clk) disable iff (rst)
        (ops.wr_ok && ops.rd_ok) |=> $stable(level));

    // R1: reset empties the buffer
    a_r1_reset_level: assert property (@(posedge clk)
        rst |=> (level == '0 && wptr == '0 && rptr == '0));

endmodule

// File: rtl/fifo_rt_store.sv
module fifo_rt_store
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int W     = 9,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  ops_t          ops,
    input  logic          oe_n,
    input  logic [AW-1:0] wptr,
    input  logic [AW-1:0] rptr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_data,
    output logic          rd_valid
);

    logic [W-1:0] mem [DEPTH];
    logic         present;

    assign present = ops.rd_ok & ~oe_n;

    always_ff @(posedge clk) begin
        if (ops.wr_ok)
            mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= present;
            rd_data  <= present ? mem[rptr] : '0;
        end
    end

    // R7: a read with the output disabled presents nothing
    a_r7_oe_hides: assert property (@(posedge clk) disable iff (rst)
        (ops.rd_ok && oe_n) |=> (!rd_valid && rd_data == '0));

    // R8: an enabled read presents a word next cycle
    a_r8_read_shows: assert property (@(posedge clk) disable iff (rst)
        (ops.rd_ok && !oe_n) |=> rd_valid);

    // R10: a read alongside a rewind presents nothing
    a_r10_rewind_wins: assert property (@(posedge clk) disable iff (rst)
        ops.rewind |=> !rd_valid);

    // R1: output idle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> !rd_valid);

endmodule

// File: rtl/fifo_rt_flags.sv
module fifo_rt_flags
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] level,
    output fill_flags_t   flags
);

    always_comb flags = decode_fill(int'(level), DEPTH);

    // R5: the empty state lies in the lower edge band
    a_r5_empty_in_band: assert property (@(posedge clk) disable iff (rst)
        !flags.empty_n |-> !flags.edge_n);

    // R6: a full buffer is also past half
    a_r6_full_past_half: assert property (@(posedge clk) disable iff (rst)
        !flags.full_n |-> !flags.half_n);

    // R5: the full state lies in the upper edge band
    a_r5_full_in_band: assert property (@(posedge clk) disable iff (rst)
        !flags.full_n |-> !flags.edge_n);

endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int W     = 9,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_n,
    input  logic [W-1:0] wr_data,
    input  logic         rd_n,
    input  logic         oe_n,
    input  logic         rewind_n,
    output logic [W-1:0] rd_data,
    output logic         rd_valid,
    output logic         full_n,
    output logic         empty_n,
    output logic         half_n,
    output logic         edge_n
);

    ops_t          ops;
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] level;
    fill_flags_t   flags;

    fifo_rt_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .wr_n     (wr_n),
        .rd_n     (rd_n),
        .rewind_n (rewind_n),
        .ops      (ops),
        .wptr     (wptr),
        .rptr     (rptr),
        .level    (level)
    );

    fifo_rt_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .ops      (ops),
        .oe_n     (oe_n),
        .wptr     (wptr),
        .rptr     (rptr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    fifo_rt_flags #(.DEPTH(DEPTH)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .level (level),
        .flags (flags)
    );

    assign full_n  = flags.full_n;
    assign empty_n = flags.empty_n;
    assign half_n  = flags.half_n;
    assign edge_n  = flags.edge_n;

    // R3: an empty buffer never presents a word on the next cycle
    a_r3_no_word_from_empty: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && wr_n) |=> !rd_valid);

endmodule

// File: tb/sim_fifo_rt.sv
`timescale 1ns/1ps
module sim_fifo_rt;

    localparam int D = 32;
    localparam int W = 9;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_n = 1'b1, rd_n = 1'b1, oe_n = 1'b1, rewind_n = 1'b1;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         rd_valid, full_n, empty_n, half_n, edge_n;

    int compared = 0;
    int mismatched = 0;

    // reference model state
    int ref_mem [D];
    int r_w = 0, r_r = 0, r_cnt = 0, r_total = 0;
    int e_q = 0;
    bit e_v = 0;
    string data_tag = "R8";

    always #2 clk = ~clk;

    fifo_rt #(.DEPTH(D), .W(W)) u0 (
        .clk(clk), .rst(rst), .wr_n(wr_n), .wr_data(wr_data), .rd_n(rd_n),
        .oe_n(oe_n), .rewind_n(rewind_n), .rd_data(rd_data), .rd_valid(rd_valid),
        .full_n(full_n), .empty_n(empty_n), .half_n(half_n), .edge_n(edge_n)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit wok, rok, rew;
        if (rst) begin
            r_w = 0; r_r = 0; r_cnt = 0; r_total = 0; e_v = 0; e_q = 0;
            return;
        end
        rew = !rewind_n;
        wok = !wr_n && r_cnt < D;
        rok = !rd_n && r_cnt > 0 && !rew;
        data_tag = (!rd_n && oe_n) ? "R7" : (rew && !rd_n) ? "R10" : "R8";
        e_v = rok && !oe_n;
        e_q = e_v ? ref_mem[r_r] : 0;
        if (wok) begin
            ref_mem[r_w] = int'(wr_data);
            r_w = (r_w + 1) % D;
            r_total++;
        end
        if (rok) r_r = (r_r + 1) % D;
        if (rew) begin
            r_r = 0;
            r_cnt = (r_w == 0 && r_total >= D) ? D : r_w;
        end else begin
            r_cnt = r_cnt + (wok ? 1 : 0) - (rok ? 1 : 0);
        end
    endtask

    task automatic compare_all(string phase);
        bit x_full, x_empty, x_half, x_edge;
        x_full  = (r_cnt < D);
        x_empty = (r_cnt > 0);
        x_half  = (2 * r_cnt <= D);
        x_edge  = (r_cnt > D / 8) && (r_cnt < D - D / 8);
        check(full_n  == x_full,  "R2", {phase, " full_n"},  int'(full_n),  int'(x_full));
        check(empty_n == x_empty, "R3", {phase, " empty_n"}, int'(empty_n), int'(x_empty));
        check(half_n  == x_half,  "R6", {phase, " half_n"},  int'(half_n),  int'(x_half));
        check(edge_n  == x_edge,  "R5", {phase, " edge_n"},  int'(edge_n),  int'(x_edge));
        check(rd_valid == e_v, data_tag, {phase, " rd_valid"}, int'(rd_valid), int'(e_v));
        check(int'(rd_data) == e_q, data_tag, {phase, " rd_data"}, int'(rd_data), e_q);
    endtask

    task automatic step(bit wn, int d, bit rn, bit oen, bit rwn, string phase);
        wr_n = wn; wr_data = W'(d); rd_n = rn; oe_n = oen; rewind_n = rwn;
        @(posedge clk);
        model_edge();
        #1;
        compare_all(phase);
    endtask

    initial begin
        #(4 * 200000);
        mismatched++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 1, "R1");
        check(full_n == 1 && half_n == 1 && empty_n == 0 && edge_n == 0 && rd_valid == 0,
              "R1", "reset flags", {full_n, half_n, empty_n, edge_n}, 4'b1100);
        rst = 1'b0;
        // R3: reads on empty are ignored
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 1, "R3");
        // R2 R5 R6: fill through every threshold, then push while full
        for (int i = 0; i < D; i++) step(0, 100 + i, 1, 1, 1, "R5/R6 fill");
        for (int i = 0; i < 3; i++) step(0, 400 + i, 1, 1, 1, "R2 overfill");
        // R7 then R8: hidden reads consume, shown reads present
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 1, "R7");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 1, "R8");
        // R9: balanced traffic
        for (int i = 0; i < 6; i++) step(0, 200 + i, 0, 0, 1, "R9");
        // R4: rewind replays from location 0; R10: read beside rewind ignored
        step(1, 0, 1, 0, 0, "R4");
        step(1, 0, 0, 0, 0, "R10");
        for (int i = 0; i < D + 3; i++) step(1, 0, 0, 0, 1, "R4 replay");
        step(1, 0, 1, 0, 1, "R8 idle");
        // R3: drained buffer again refuses reads
        step(1, 0, 0, 0, 1, "R3 drained");
        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            int k;
            bit wn, rn, oen, rwn;
            k = $urandom_range(0, 99);
            rwn = !(k < 2);
            wn  = rwn ? ($urandom_range(0, 99) < 55 ? 1'b0 : 1'b1) : 1'b1;
            rn  = $urandom_range(0, 99) < 50 ? 1'b0 : 1'b1;
            oen = $urandom_range(0, 3) == 0;
            step(wn, int'($urandom_range(0, 511)), rn, oen, rwn, "mix R9");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule